// File: doc/BRIEF.md
# Motor PWM Channel with Edge and Center Alignment

This block is one channel of a motor-control pulse-width modulator. A timer counter runs against a period value and a compare value, and the channel drives a complementary pair of outputs, A and B. A high level on an output means active. In edge-aligned operation the counter climbs from zero to the period value and wraps. In center-aligned operation it climbs to the period value and then falls back to zero, so the pulses are symmetric about the top of the count. A compare hit turns one output passive and, when dead-time insertion is off, turns the other output active on the same clock edge.

Period and compare values are written through a small write port into staging registers. The comparison logic uses separate operating registers, which take the staged values only at a period boundary, so a write never produces a partial period. Turn-on delay between the two outputs is not done here. With dead-time insertion enabled, a compare hit only turns an output passive. The block then emits a one-cycle trigger and a count-direction flag for an external dead-time unit.

Top module: `mpwm_channel`

## Requirements
- R1: After reset outB is 1, outA is 0 and dtTrig is 0. Both staging registers and both operating registers are all ones, so with no writes the outputs stay at B active, A passive.
- R2: A write with wrEn=1 stores wrData in the staging period register when wrSel=0, and in the staging compare register when wrSel=1. The operating registers take the staged values only at a period boundary: the cycle with counter equal to the period value in edge mode, or the cycle with counter equal to zero in center mode. A write therefore leaves the period that is already running unchanged.
- R3: In edge mode (centerMode=0) the counter runs 0..L and wraps, giving a period of L+1 cycles. At the wrap, B returns to active and A to passive, unless the compare value taking effect is zero.
- R4: In edge mode with deadTimeEn=0 and compare value M<L, outB is high for M+1 cycles and low for L-M cycles per period, and outA is the complement of outB.
- R5: In center mode (centerMode=1) the period is 2L cycles. A hit while counting up turns B passive and A active. A hit while counting down turns A passive and B active. With deadTimeEn=0 this gives outB high for 2M cycles and low for 2(L-M) cycles, with outA the complement of outB.
- R6: A compare value that is not below the period value never produces a hit, so outB stays 1 and outA stays 0.
- R7: A compare value of zero holds the outputs at outA=1 and outB=0 in both modes, with deadTimeEn=0.
- R8: In edge mode with deadTimeEn=1, each hit drives outB low. In the same cycle dtTrig is high for exactly one cycle and dtDirUp is 1. outA stays 0. The triggers are L+1 cycles apart.
- R9: In center mode with deadTimeEn=1, an up-count hit gives dtTrig with dtDirUp=1, and a down-count hit gives dtTrig with dtDirUp=0, 2(L-M) cycles later. A hit turns no output active, so both outputs stay 0.
- R10: outA and outB are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the staging registers |
| wrSel | input | 1 | 0 selects the period register, 1 selects the compare register |
| wrData | input | CNT_W | Value to stage |
| centerMode | input | 1 | 0 selects edge-aligned counting, 1 selects center-aligned counting |
| deadTimeEn | input | 1 | 1 hands output turn-on to an external dead-time unit |
| outA | output | 1 | Output A, high when active |
| outB | output | 1 | Output B, high when active |
| dtTrig | output | 1 | One-cycle request to the dead-time unit |
| dtDirUp | output | 1 | Count direction at the last hit (1 = up) |

## Verification
The assertions assume that centerMode and deadTimeEn change only while rstN is low. Under that assumption, the operating registers can change only in a boundary cycle, and the counter never passes the operating period value. The bench sets both mode inputs before each reset and holds them for the whole test, and it writes the staging registers at arbitrary points in a period. Each test first waits long enough for the staged values to reach the operating registers, and then measures pulse widths from the outputs alone.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  // Counter and boundary strobes from control to datapath
  typedef struct packed {
    logic load;      // copy staging values into operating registers
    logic cntClear;  // counter to zero
    logic cntInc;    // counter up by one
    logic cntDec;    // counter down by one
    logic goUp;      // direction becomes up
    logic goDown;    // direction becomes down
  } cntStrobe_t;
endpackage

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  cntStrobe_t       stb,
  output logic [CNT_W-1:0] tc,
  output logic             dirUp,
  output logic [CNT_W-1:0] limW,
  output logic [CNT_W-1:0] matW,
  output logic [CNT_W-1:0] limOp,
  output logic [CNT_W-1:0] matOp
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limW <= '1;
      matW <= '1;
    end else if (wrEn) begin
      if (wrSel) matW <= wrData;
      else       limW <= wrData;
    end
  end

  // operating registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limOp <= '1;
      matOp <= '1;
    end else if (stb.load) begin
      limOp <= limW;
      matOp <= matW;
    end
  end

  // timer counter and direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tc    <= '0;
      dirUp <= 1'b1;
    end else begin
      if (stb.cntClear)    tc <= '0;
      else if (stb.cntInc) tc <= tc + ONE;
      else if (stb.cntDec) tc <= tc - ONE;
      if (stb.goUp)        dirUp <= 1'b1;
      else if (stb.goDown) dirUp <= 1'b0;
    end
  end

  // R3 R5: counter never passes the operating period value
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tc <= limOp);
endmodule

// File: rtl/mpwm_control.sv
module mpwm_control
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             centerMode,
  input  logic             deadTimeEn,
  input  logic [CNT_W-1:0] tc,
  input  logic             dirUp,
  input  logic [CNT_W-1:0] limW,
  input  logic [CNT_W-1:0] matW,
  input  logic [CNT_W-1:0] limOp,
  input  logic [CNT_W-1:0] matOp,
  output cntStrobe_t       stb,
  output logic             outA,
  output logic             outB,
  output logic             dtTrig,
  output logic             dtDirUp
);
  logic atLim, atZero, hit, effUp, holdAtWrap;
  logic aOn, bOn, trig, dirFlag;

  assign atLim      = (tc == limOp);
  assign atZero     = (tc == '0);
  assign hit        = (tc == matOp) && (matOp < limOp);
  assign effUp      = atZero || dirUp;
  assign holdAtWrap = (matW == '0) && (limW != '0);

  // counter sequencing
  always_comb begin
    stb = '0;
    if (!centerMode) begin
      stb.goUp     = 1'b1;
      stb.load     = atLim;
      stb.cntClear = atLim;
      stb.cntInc   = !atLim;
    end else if (atZero) begin
      stb.load     = 1'b1;
      stb.goUp     = 1'b1;
      stb.cntInc   = (limW != '0);
      stb.cntClear = (limW == '0);
    end else if (dirUp && tc >= limOp) begin
      stb.goDown = 1'b1;
      stb.cntDec = 1'b1;
    end else if (dirUp) begin
      stb.cntInc = 1'b1;
    end else begin
      stb.cntDec = 1'b1;
    end
  end

  // output pair and dead-time hooks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOn     <= 1'b0;
      bOn     <= 1'b1;
      trig    <= 1'b0;
      dirFlag <= 1'b1;
    end else begin
      trig <= 1'b0;
      if (hit && (effUp || !centerMode)) begin
        bOn     <= 1'b0;
        aOn     <= !deadTimeEn;
        trig    <= deadTimeEn;
        dirFlag <= 1'b1;
      end else if (hit) begin
        aOn     <= 1'b0;
        bOn     <= !deadTimeEn;
        trig    <= deadTimeEn;
        dirFlag <= 1'b0;
      end else if (!centerMode && atLim && !holdAtWrap) begin
        bOn <= 1'b1;
        aOn <= 1'b0;
      end
    end
  end

  assign outA    = aOn;
  assign outB    = bOn;
  assign dtTrig  = trig;
  assign dtDirUp = dirFlag;

  // R10
  ab_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB));
  // R8
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dtTrig |=> !dtTrig);
  // R8
  trig_needs_dt_chk: assert property (@(posedge clk) disable iff (!rstN)
    dtTrig |-> deadTimeEn);
  // R4
  b_fall_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outB) |-> $past(tc == matOp));
  // R3
  edge_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!centerMode && tc == limOp) |=> (tc == '0));
  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!centerMode && tc != limOp) |=> ($stable(limOp) && $stable(matOp)));
  // R2
  center_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (centerMode && tc != '0) |=> ($stable(limOp) && $stable(matOp)));
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             centerMode,
  input  logic             deadTimeEn,
  output logic             outA,
  output logic             outB,
  output logic             dtTrig,
  output logic             dtDirUp
);
  cntStrobe_t       stb;
  logic [CNT_W-1:0] tc, limW, matW, limOp, matOp;
  logic             dirUp;

  mpwm_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .stb(stb), .tc(tc), .dirUp(dirUp), .limW(limW), .matW(matW),
    .limOp(limOp), .matOp(matOp)
  );

  mpwm_control #(.CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN), .centerMode(centerMode), .deadTimeEn(deadTimeEn),
    .tc(tc), .dirUp(dirUp), .limW(limW), .matW(matW), .limOp(limOp),
    .matOp(matOp), .stb(stb), .outA(outA), .outB(outB), .dtTrig(dtTrig),
    .dtDirUp(dtDirUp)
  );
endmodule

// File: tb/mpwm_channel_bench.sv
module mpwm_channel_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         centerMode = 1'b0;
  logic         deadTimeEn = 1'b0;
  logic         outA, outB, dtTrig, dtDirUp;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mpwm_channel #(.CNT_W(W)) u_mpwm_channel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .centerMode(centerMode), .deadTimeEn(deadTimeEn), .outA(outA),
    .outB(outB), .dtTrig(dtTrig), .dtDirUp(dtDirUp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input int val);
    wrEn = 1'b1; wrSel = sel; wrData = W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startUp(input logic ctr, input logic dte);
    rstN = 1'b0; centerMode = ctr; deadTimeEn = dte;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic ctr, input logic dte, input int lim, input int mat);
    startUp(ctr, dte);
    writeReg(1'b0, lim);
    writeReg(1'b1, mat);
    repeat (600) @(negedge clk);
  endtask

  task automatic countRun(input logic lvl, output int n);
    n = 0;
    while (outB === lvl && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic syncRise();
    int guard = 0;
    while (outB !== 1'b0 && guard < 4000) begin guard++; @(negedge clk); end
    while (outB !== 1'b1 && guard < 8000) begin guard++; @(negedge clk); end
  endtask

  task automatic syncTrig();
    int guard = 0;
    while (dtTrig !== 1'b1 && guard < 4000) begin guard++; @(negedge clk); end
  endtask

  task automatic steadyCheck(input string tag, input logic expA, input logic expB);
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (outA !== expA || outB !== expB) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic complementCheck(input string tag);
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (outA !== ~outB) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic testReset();
    startUp(1'b0, 1'b0);
    chk(outB === 1'b1, "R1 outB after reset", int'(outB), 1);
    chk(outA === 1'b0, "R1 outA after reset", int'(outA), 0);
    chk(dtTrig === 1'b0, "R1 dtTrig after reset", int'(dtTrig), 0);
    steadyCheck("R1 no hit with reset compare value", 1'b0, 1'b1);
  endtask

  task automatic testEdgePwm();
    int hi, lo;
    setup(1'b0, 1'b0, 9, 4);
    syncRise();
    countRun(1'b1, hi);
    countRun(1'b0, lo);
    chk(hi == 5, "R4 edge high width", hi, 5);
    chk(lo == 5, "R4 edge low width", lo, 5);
    chk(hi + lo == 10, "R3 edge period", hi + lo, 10);
    complementCheck("R4 R10 edge A complements B");
  endtask

  task automatic testEdgeBuffer();
    int hi, lo, hi2, lo2;
    setup(1'b0, 1'b0, 9, 4);
    syncRise();
    countRun(1'b1, hi);
    lo = 1;
    writeReg(1'b0, 15);
    while (outB === 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
    countRun(1'b1, hi2);
    countRun(1'b0, lo2);
    chk(lo == 5, "R2 running period untouched by write", lo, 5);
    chk(hi2 == 5, "R2 next period high width", hi2, 5);
    chk(lo2 == 11, "R2 new period value applied", lo2, 11);
  endtask

  task automatic testCenterPwm();
    int hi, lo;
    setup(1'b1, 1'b0, 10, 4);
    syncRise();
    countRun(1'b1, hi);
    countRun(1'b0, lo);
    chk(hi == 8, "R5 center high width", hi, 8);
    chk(lo == 12, "R5 center low width", lo, 12);
    complementCheck("R5 R10 center A complements B");
  endtask

  task automatic testMatchAbove();
    setup(1'b0, 1'b0, 9, 12);
    steadyCheck("R6 edge compare above period", 1'b0, 1'b1);
    setup(1'b1, 1'b0, 10, 10);
    steadyCheck("R6 center compare equal to period", 1'b0, 1'b1);
  endtask

  task automatic testMatchZero();
    setup(1'b0, 1'b0, 9, 0);
    steadyCheck("R7 edge compare zero", 1'b1, 1'b0);
    setup(1'b1, 1'b0, 10, 0);
    steadyCheck("R7 center compare zero", 1'b1, 1'b0);
  endtask

  task automatic testEdgeDead();
    int gap;
    setup(1'b0, 1'b1, 9, 3);
    syncTrig();
    chk(outB === 1'b0, "R8 B passive with trigger", int'(outB), 0);
    chk(dtDirUp === 1'b1, "R8 direction flag up", int'(dtDirUp), 1);
    chk(outA === 1'b0, "R8 A left passive", int'(outA), 0);
    @(negedge clk);
    chk(dtTrig === 1'b0, "R8 trigger lasts one cycle", int'(dtTrig), 0);
    gap = 1;
    while (dtTrig !== 1'b1 && gap < 4000) begin gap++; @(negedge clk); end
    chk(gap == 10, "R8 trigger spacing", gap, 10);
  endtask

  task automatic testCenterDead();
    int gap;
    setup(1'b1, 1'b1, 10, 4);
    syncTrig();
    while (dtDirUp !== 1'b1 && gap < 4000) begin
      gap++; @(negedge clk); syncTrig();
    end
    chk(dtDirUp === 1'b1, "R9 up hit flag", int'(dtDirUp), 1);
    @(negedge clk);
    gap = 1;
    while (dtTrig !== 1'b1 && gap < 4000) begin gap++; @(negedge clk); end
    chk(gap == 12, "R9 up to down trigger spacing", gap, 12);
    chk(dtDirUp === 1'b0, "R9 down hit flag", int'(dtDirUp), 0);
    steadyCheck("R9 no output turned active", 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testEdgePwm();
        testEdgeBuffer();
        testCenterPwm();
        testMatchAbove();
        testMatchZero();
        testEdgeDead();
        testCenterDead();
      end
      begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule